// File: doc/BRIEF.md
# Dual-Speed CPU Clock Generator

This block produces the processor clock for a Z80-class machine that has been fitted with fast local SRAM. It runs from a timebase clock at `TICKS_PER_OSC` times the crystal oscillator (default 4, so about 70.9 MHz for a 17.73 MHz crystal). It makes two rates from that timebase. The slow rate is the original machine speed, the crystal divided by five, with a mark of 3 and a space of 2 crystal periods. The fast rate is either the crystal frequency itself (5x the original) or, when `FAST_X4` is set, four times the original rate.

Every bus cycle is classified from the strobes, the address and the three bank-inhibit flags. The slow rate is used for I/O, refresh, ROM reads, the peripheral window and board DRAM. The fast rate is used for everything else, which is the SRAM, and for bus-idle time. The rate is never changed by dropping or gating pulses. Instead, the phase in progress is stretched to the slow length, or cut short at the next tick, so every phase stays a whole number of ticks and at least the fast phase length. The speed decision is taken in the tick where MREQ or IORQ first goes active and is held until both strobes are released.

Two small state machines do the work. The bus tracker has states `TRK_IDLE`, `TRK_SLOW` and `TRK_FAST`:
- `TRK_IDLE` goes to `TRK_SLOW` or `TRK_FAST` when a strobe appears, according to the decode.
- Either active state returns to `TRK_IDLE` when no strobe remains.
- Reset sends the tracker to `TRK_IDLE`.

The phase generator has states `PH_HI` and `PH_LO`. It moves `PH_HI` to `PH_LO` and `PH_LO` to `PH_HI` when the tick count of the current phase reaches the limit for the present speed. The processor clock is the `PH_HI` state bit itself.

Top module: `dual_speed_clkgen`

## Requirements
- R1: While rst_n is low, slow_o is 1 and cpu_clk keeps toggling at the slow rate, with a high phase of 3*TICKS_PER_OSC ticks and a low phase of 2*TICKS_PER_OSC ticks (12 and 8 by default).
- R2: With mreq_n and iorq_n both high, the clock runs fast and slow_o reads 0 at the first edge after both strobes are high. With FAST_X4=0 each fast phase is TICKS_PER_OSC/2 ticks (2 and 2 by default).
- R3: A cycle with iorq_n low runs slow.
- R4: A memory read (mreq_n and rd_n low) in 0x0000–0x0FFF with bank_inh[0]=1 runs slow. A memory write in that range with bank_inh[0]=1 runs fast.
- R5: A memory access in 0xE000–0xE00F with bank_inh[1]=1 and bank_inh[2]=1 runs slow. The same flags with an address from 0xE010 upward run fast.
- R6: A memory access that falls in board DRAM runs slow. DRAM is 0x1000–0xCFFF, 0x0000–0x0FFF with bank_inh[0]=0, and 0xD000–0xFFFF with bank_inh[1]=0 and bank_inh[2]=1. Every other memory access runs fast.
- R7: A memory cycle that starts with rfsh_n low runs slow.
- R8: The speed is decided in the tick where a strobe first goes low. It is then held while either strobe stays low, and changes to the address, flags, rd_n or the other strobe are ignored.
- R9: A change of speed acts on the phase in progress. If the speed becomes slow, the phase lasts the slow length counted from its start. If the speed becomes fast and the phase is already at or past the fast length, it ends at the next tick. Every phase lasts between the fast low length and the slow high length.
- R10: slow_o shows the new speed at the first timebase edge after a strobe goes low. It reads 0 before that edge if the bus was idle.
- R11: With FAST_X4=1 the fast period is 5*TICKS_PER_OSC/4 ticks, with a high phase of 3 ticks and a low phase of 2 ticks by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock, TICKS_PER_OSC times the crystal |
| rst_n | input | 1 | Asynchronous active-low reset; forces slow speed |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rfsh_n | input | 1 | Refresh indicator, active low |
| addr | input | 16 | CPU address bus |
| bank_inh | input | 3 | Bank-inhibit flags: bit 0 low bank, bit 1 second, bit 2 third |
| cpu_clk | output | 1 | Generated CPU clock |
| slow_o | output | 1 | 1 while the slow rate is in force |

## Verification
The bench drives inputs on the falling timebase edge and reads outputs on the next falling edge, so the one register stage to slow_o places each speed decision exactly one sample after the strobe goes low and the release one sample after the strobes go high. Phase lengths are read as runs of equal cpu_clk samples. Because the phase register is loaded on the same edge that sees a new strobe, a strobe driven on the first high sample of a fast phase must give a high run of the full slow length, 12 samples. A release on the fifth sample of a slow high phase must end that phase at 5 samples, followed by a 2-sample fast low phase. Every combination of page, inhibit flags, cycle type and window-edge offset is swept, and each one is checked against an arithmetic model of the decode.

// File: rtl/dsclk_pkg.sv
`timescale 1ns/1ps
package dsclk_pkg;

    localparam int ADDR_W = 16;
    localparam logic [11:0] PERIPH_PAGE = 12'hE00;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_SLOW = 2'd1,
        TRK_FAST = 2'd2
    } trk_state_t;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_t;

    // slow rate: crystal / 5 with a 3:2 mark-to-space split
    function automatic int slow_hi_ticks(input int tpo);
        return 3 * tpo;
    endfunction

    function automatic int slow_lo_ticks(input int tpo);
        return 2 * tpo;
    endfunction

    // fast period: crystal rate, or 4x the slow rate
    function automatic int fast_period(input int tpo, input bit x4);
        return x4 ? (5 * tpo) / 4 : tpo;
    endfunction

    function automatic int fast_lo_ticks(input int tpo, input bit x4);
        return fast_period(tpo, x4) / 2;
    endfunction

    function automatic int fast_hi_ticks(input int tpo, input bit x4);
        return fast_period(tpo, x4) - fast_period(tpo, x4) / 2;
    endfunction

endpackage

// File: rtl/dsclk_decode.sv
`timescale 1ns/1ps
module dsclk_decode
    import dsclk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bank_inh,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              rfsh_n,
    output logic              need_slow
);

    logic [3:0] page;
    logic       rom_hit;
    logic       periph_hit;
    logic       dram_hit;
    logic       mem_cyc;

    assign page    = addr[ADDR_W-1 -: 4];
    assign mem_cyc = !mreq_n;

    always_comb begin
        rom_hit    = mem_cyc && !rd_n && (page == 4'd0) && bank_inh[0];
        periph_hit = mem_cyc && (addr[ADDR_W-1:4] == PERIPH_PAGE)
                     && bank_inh[1] && bank_inh[2];
        dram_hit   = mem_cyc && (((page == 4'd0) && !bank_inh[0])
                     || ((page >= 4'd1) && (page <= 4'd12))
                     || ((page > 4'd12) && !bank_inh[1] && bank_inh[2]));
        need_slow  = !iorq_n || (mem_cyc && !rfsh_n)
                     || rom_hit || periph_hit || dram_hit;
    end

endmodule

// File: rtl/dsclk_tracker.sv
`timescale 1ns/1ps
module dsclk_tracker
    import dsclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic need_slow,
    output logic slow_now
);

    trk_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TRK_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TRK_IDLE: if (strobe) st_nx = need_slow ? TRK_SLOW : TRK_FAST;
            TRK_SLOW: if (!strobe) st_nx = TRK_IDLE;
            TRK_FAST: if (!strobe) st_nx = TRK_IDLE;
            default:  st_nx = TRK_IDLE;
        endcase
    end

    // the decision reaches the generator in the very tick the strobe appears
    always_comb begin
        slow_now = !rst_n
                   || (strobe && ((st == TRK_SLOW)
                                  || ((st == TRK_IDLE) && need_slow)));
    end

endmodule

// File: rtl/dsclk_phase.sv
`timescale 1ns/1ps
module dsclk_phase
    import dsclk_pkg::*;
#(
    parameter int SLOW_HI = 12,
    parameter int SLOW_LO = 8,
    parameter int FAST_HI = 2,
    parameter int FAST_LO = 2
) (
    input  logic clk,
    input  logic slow,
    output logic cpu_clk
);

    localparam int CNT_W = $clog2(SLOW_HI + 1);

    phase_t           ph, ph_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    int               limit;
    logic             done;

    // self-starting: any power-up value ends its phase within SLOW_HI ticks
    always_ff @(posedge clk) begin
        ph  <= ph_nx;
        cnt <= cnt_nx;
    end

    always_comb begin
        unique case (ph)
            PH_HI:   limit = slow ? SLOW_HI : FAST_HI;
            PH_LO:   limit = slow ? SLOW_LO : FAST_LO;
            default: limit = FAST_LO;
        endcase
        done   = (int'(cnt) + 1) >= limit;
        ph_nx  = done ? ((ph == PH_HI) ? PH_LO : PH_HI) : ph;
        cnt_nx = done ? '0 : cnt + CNT_W'(1);
    end

    assign cpu_clk = (ph == PH_HI);

endmodule

// File: rtl/dual_speed_clkgen.sv
`timescale 1ns/1ps
module dual_speed_clkgen
    import dsclk_pkg::*;
#(
    parameter int TICKS_PER_OSC = 4,
    parameter bit FAST_X4       = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              rfsh_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bank_inh,
    output logic              cpu_clk,
    output logic              slow_o
);

    localparam int SLOW_HI = slow_hi_ticks(TICKS_PER_OSC);
    localparam int SLOW_LO = slow_lo_ticks(TICKS_PER_OSC);
    localparam int FAST_HI = fast_hi_ticks(TICKS_PER_OSC, FAST_X4);
    localparam int FAST_LO = fast_lo_ticks(TICKS_PER_OSC, FAST_X4);

    logic strobe;
    logic need_slow;
    logic slow_now;

    assign strobe = !mreq_n || !iorq_n;

    dsclk_decode u_decode (
        .addr      (addr),
        .bank_inh  (bank_inh),
        .mreq_n    (mreq_n),
        .iorq_n    (iorq_n),
        .rd_n      (rd_n),
        .rfsh_n    (rfsh_n),
        .need_slow (need_slow)
    );

    dsclk_tracker u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .need_slow (need_slow),
        .slow_now  (slow_now)
    );

    dsclk_phase #(
        .SLOW_HI (SLOW_HI),
        .SLOW_LO (SLOW_LO),
        .FAST_HI (FAST_HI),
        .FAST_LO (FAST_LO)
    ) u_phase (
        .clk     (clk),
        .slow    (slow_now),
        .cpu_clk (cpu_clk)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slow_o <= 1'b1;
        else        slow_o <= slow_now;
    end

endmodule

// File: rtl/dsclk_chk.sv
`timescale 1ns/1ps
module dsclk_chk
    import dsclk_pkg::*;
#(
    parameter int TICKS_PER_OSC = 4,
    parameter bit FAST_X4       = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic mreq_n,
    input logic iorq_n,
    input logic rfsh_n,
    input logic cpu_clk,
    input logic slow_o
);

    localparam int LONGEST  = slow_hi_ticks(TICKS_PER_OSC);
    localparam int SHORTEST = fast_lo_ticks(TICKS_PER_OSC, FAST_X4);

    logic       strobe;
    logic [1:0] since_rst;
    logic [1:0] edges;
    logic       cpu_q;
    int         run;

    assign strobe = !mreq_n || !iorq_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
            edges     <= 2'd0;
            cpu_q     <= 1'b0;
            run       <= 0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            cpu_q <= cpu_clk;
            if (cpu_clk != cpu_q) begin
                run <= 1;
                if (edges != 2'd3) edges <= edges + 2'd1;
            end else if (run <= LONGEST) begin
                run <= run + 1;
            end
        end
    end

    // R2
    r2_idle_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(!strobe)) |-> !slow_o);

    // R3
    r3_io_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(!iorq_n) && $past(mreq_n && iorq_n, 2))
        |-> slow_o);

    // R7
    r7_refresh_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(!mreq_n && !rfsh_n)
         && $past(mreq_n && iorq_n, 2)) |-> slow_o);

    // R8
    r8_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(strobe) && $past(strobe, 2))
        |-> (slow_o == $past(slow_o)));

    // R9
    r9_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edges >= 2'd2 && cpu_clk != cpu_q)
        |-> (run >= SHORTEST && run <= LONGEST));

endmodule

bind dual_speed_clkgen dsclk_chk #(
    .TICKS_PER_OSC (TICKS_PER_OSC),
    .FAST_X4       (FAST_X4)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mreq_n  (mreq_n),
    .iorq_n  (iorq_n),
    .rfsh_n  (rfsh_n),
    .cpu_clk (cpu_clk),
    .slow_o  (slow_o)
);

// File: tb/sim_dual_speed_clkgen.sv
`timescale 1ns/1ps
module sim_dual_speed_clkgen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mreq_n, iorq_n, rd_n, rfsh_n;
    logic [15:0] addr;
    logic [2:0]  bank_inh;
    logic        cpu_clk, slow_o, cpu_clk4, slow4;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_speed_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .rfsh_n(rfsh_n), .addr(addr), .bank_inh(bank_inh),
        .cpu_clk(cpu_clk), .slow_o(slow_o)
    );

    dual_speed_clkgen #(.FAST_X4(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .rfsh_n(rfsh_n), .addr(addr), .bank_inh(bank_inh),
        .cpu_clk(cpu_clk4), .slow_o(slow4)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic pick(input bit x4);
        return x4 ? cpu_clk4 : cpu_clk;
    endfunction

    // kind: 0 mem read, 1 mem write, 2 io, 3 refresh
    function automatic bit exp_slow(input logic [15:0] a, input logic [2:0] f,
                                    input int kind);
        int pg;
        pg = int'(a[15:12]);
        if (kind == 2) return 1'b1;
        if (kind == 3) return 1'b1;
        if (pg == 0) return f[0] ? (kind == 0) : 1'b1;
        if (pg <= 12) return 1'b1;
        if (a[15:4] == 12'hE00 && f[1] && f[2]) return 1'b1;
        if (!f[1] && f[2]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic [2:0] f,
                                     input int kind);
        if (kind == 2) return "R3 io";
        if (kind == 3) return "R7 refresh";
        if (a[15:12] == 4'd0 && f[0]) return "R4 rom window";
        if (a[15:4] == 12'hE00) return "R5 peripheral window";
        return "R6 dram/sram map";
    endfunction

    task automatic phases(input bit x4, output int hi, output int lo);
        logic p, c;
        @(negedge clk);
        p = pick(x4);
        c = p;
        while (!(!p && c)) begin
            p = c;
            @(negedge clk);
            c = pick(x4);
        end
        hi = 1;
        @(negedge clk);
        c = pick(x4);
        while (c) begin
            hi++;
            @(negedge clk);
            c = pick(x4);
        end
        lo = 1;
        @(negedge clk);
        c = pick(x4);
        while (!c) begin
            lo++;
            @(negedge clk);
            c = pick(x4);
        end
    endtask

    task automatic release_bus();
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; rfsh_n = 1'b1;
    endtask

    task automatic bus_op(input logic [15:0] a, input logic [2:0] f, input int kind);
        bit e;
        string t;
        @(negedge clk);
        addr = a; bank_inh = f;
        @(negedge clk);
        chk("R10 idle before strobe", slow_o, 0);
        e = exp_slow(a, f, kind);
        t = tag_of(a, f, kind);
        unique case (kind)
            0:       begin mreq_n = 1'b0; rd_n = 1'b0; end
            1:       mreq_n = 1'b0;
            2:       begin iorq_n = 1'b0; rd_n = 1'b0; end
            default: begin mreq_n = 1'b0; rfsh_n = 1'b0; end
        endcase
        @(negedge clk);
        chk(t, slow_o, int'(e));
        @(negedge clk);
        chk("R8 decision held", slow_o, int'(e));
        release_bus();
        @(negedge clk);
        chk("R2 fast after release", slow_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hi, lo;
        logic c;
        logic [11:0] off;
        rst_n = 1'b0;
        release_bus();
        addr = 16'h0000;
        bank_inh = 3'b111;

        // R1: slow toggling under reset
        repeat (3) @(negedge clk);
        chk("R1 slow flag in reset", slow_o, 1);
        phases(1'b0, hi, lo);
        chk("R1 reset high phase", hi, 12);
        chk("R1 reset low phase", lo, 8);
        phases(1'b1, hi, lo);
        chk("R1 reset high phase x4 build", hi, 12);
        chk("R1 reset low phase x4 build", lo, 8);

        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 fast after reset", slow_o, 0);
        phases(1'b0, hi, lo);
        chk("R2 idle high phase", hi, 2);
        chk("R2 idle low phase", lo, 2);
        // R11
        phases(1'b1, hi, lo);
        chk("R11 x4 high phase", hi, 3);
        chk("R11 x4 low phase", lo, 2);

        // R3 R4 R5 R6 R7 R8 R10: sweep of pages, flags, kinds, offsets
        for (int pg = 0; pg < 16; pg++) begin
            for (int f = 0; f < 8; f++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int o = 0; o < 4; o++) begin
                        unique case (o)
                            0:       off = 12'h000;
                            1:       off = 12'h00F;
                            2:       off = 12'h010;
                            default: off = 12'hFFF;
                        endcase
                        bus_op({pg[3:0], off}, f[2:0], k);
                    end
                end
            end
        end

        // R8: bus changes during a held slow cycle
        @(negedge clk);
        addr = 16'h2000; bank_inh = 3'b111;
        mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R8 slow taken", slow_o, 1);
        addr = 16'hD000; bank_inh = 3'b011;
        @(negedge clk);
        chk("R8 slow held over address change", slow_o, 1);
        rd_n = 1'b1;
        @(negedge clk);
        chk("R8 slow held over rd change", slow_o, 1);
        release_bus();
        @(negedge clk);
        chk("R2 release after held slow", slow_o, 0);

        // R8: bus changes during a held fast cycle
        mreq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        chk("R6 sram fast", slow_o, 0);
        addr = 16'h2000; bank_inh = 3'b000;
        @(negedge clk);
        chk("R8 fast held over address change", slow_o, 0);
        iorq_n = 1'b0;
        @(negedge clk);
        chk("R8 fast held over iorq", slow_o, 0);
        release_bus();
        @(negedge clk);
        chk("R2 release after held fast", slow_o, 0);

        // R9: stretch a fast high phase to the slow mark
        @(negedge clk);
        c = cpu_clk;
        while (c) begin
            @(negedge clk);
            c = cpu_clk;
        end
        while (!c) begin
            @(negedge clk);
            c = cpu_clk;
        end
        iorq_n = 1'b0; rd_n = 1'b0;
        hi = 1;
        @(negedge clk);
        c = cpu_clk;
        while (c) begin
            hi++;
            @(negedge clk);
            c = cpu_clk;
        end
        lo = 1;
        @(negedge clk);
        c = cpu_clk;
        while (!c) begin
            lo++;
            @(negedge clk);
            c = cpu_clk;
        end
        chk("R9 stretched high phase", hi, 12);
        chk("R9 slow low phase", lo, 8);
        chk("R3 slow during io", slow_o, 1);

        // R9: cut a slow high phase short on release
        phases(1'b0, hi, lo);
        chk("R9 held slow high", hi, 12);
        chk("R9 held slow low", lo, 8);
        for (int i = 1; i < 5; i++) @(negedge clk);
        release_bus();
        hi = 5;
        @(negedge clk);
        c = cpu_clk;
        while (c) begin
            hi++;
            @(negedge clk);
            c = cpu_clk;
        end
        lo = 1;
        @(negedge clk);
        c = cpu_clk;
        while (!c) begin
            lo++;
            @(negedge clk);
            c = cpu_clk;
        end
        chk("R9 shortened high phase", hi, 5);
        chk("R9 fast low after release", lo, 2);

        // R1: reset asserted while running fast
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 slow on reset entry", slow_o, 1);
        phases(1'b0, hi, lo);
        chk("R1 mid-run reset high", hi, 12);
        chk("R1 mid-run reset low", lo, 8);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 fast after second reset", slow_o, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule